// File: doc/BRIEF.md
# Record Framer for an 8b10b Output Link

This block sits between a readout FIFO holding 24-bit record words and an 8b10b encoder. It reads records from the FIFO head, breaks each one into three bytes with the most significant byte first, and emits a byte stream with a control flag (`sym_k`). While no record is waiting, the stream carries idle commas. A data event is opened with a start-of-frame comma when a data header sits at the FIFO head. The event is closed with an end-of-frame comma when its last record has gone out, when the FIFO has nothing more to offer, or when a new header is waiting. Address, value and service records that arrive outside an event are sent without framing.

The control characters are K28.7 for start of frame, K28.5 for end of frame and K28.1 for idle. A raw mode, used when the downstream encoder is bypassed, replaces every control slot with an empty record: three copies of a programmable filler byte, each sent with the flag low. This keeps the output aligned on 24-bit boundaries. An event may carry only one service record, and the block discards any further service record inside the same event.

The state machine has five states:

- `ST_IDLE` sends an idle slot.
- `ST_SOF` sends the start comma.
- `ST_REC` sends the three bytes of the held record.
- `ST_EOF` sends the end comma.
- `ST_SKIP` is a single cycle with no output, used to discard a surplus service record.

At the end of every slot the machine takes one of five actions:

- `ACT_IDLE`: stay idle.
- `ACT_SOF`: open a frame.
- `ACT_LOAD`: pop the FIFO head and send it.
- `ACT_EOF`: close the frame.
- `ACT_SKIP`: pop the head and drop it.

Which action it takes depends on whether a frame is open. Inside a frame, the machine closes the frame or loads, or it skips a surplus service record. Outside a frame, it opens a frame, loads an unframed record, or idles. When the start comma is sent, the header is always loaded next.

Top module: `record_framer`

## Requirements
- R1: After reset the output is valid and carries an idle slot: byte 0x3C (K28.1) with `sym_k`=1 in normal mode. `rec_ready` stays low while the FIFO is empty.
- R2: A record whose top byte is 0xE9 (tag 11101, type 001: data header) at the FIFO head outside a frame causes byte 0xFC (K28.7, `sym_k`=1), followed by the header's own bytes.
- R3: Every record is sent as three bytes in the order bits [23:16], [15:8], [7:0], each with `sym_k`=0.
- R4: An open frame is closed by byte 0xBC (K28.5, `sym_k`=1) after a record that had `rec_last`=1, or when the FIFO is empty at the end of a record, or when the next head is a data header. In the last case the start comma follows directly after the end comma.
- R5: Two accepted start-of-frame commas are never adjacent in the output stream.
- R6: Non-header records found at the FIFO head outside a frame are sent with no start or end comma around them.
- R7: Inside a frame, a second record with top byte 0xEF (tag 11101, type 111: service record) is popped and produces no output bytes. If it carried `rec_last`=1, the end comma follows.
- R8: With `raw_mode`=1, every idle, start and end slot becomes three bytes equal to `filler_byte` with `sym_k`=0, and `sym_k` is never raised.
- R9: While `sym_valid`=1 and `sym_ready`=0, the output byte and flag hold. At most one byte is accepted per cycle. `rec_ready` is raised only when `rec_valid`=1.
- R10: A data record whose 7-bit column field lies in 1 to 80 (top five bits never 11101) is never taken as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rec_valid | input | 1 | FIFO head holds a record |
| rec_data | input | 24 | Record word at the FIFO head |
| rec_last | input | 1 | Head record ends its event |
| rec_ready | output | 1 | Pop the FIFO head this cycle |
| raw_mode | input | 1 | Replace control symbols by filler bytes |
| filler_byte | input | 8 | Byte used for empty records in raw mode |
| sym_valid | output | 1 | Output byte is valid |
| sym_ready | input | 1 | Downstream accepts the byte |
| sym_data | output | 8 | Output byte |
| sym_k | output | 1 | Output byte is a control character |

## Verification
The bench targets several corner cases, each with a distinct failure signature:

- **Header arriving inside an open frame.** A framer that merged the two events would emit the second start comma without the end comma before it.
- **Surplus service record, with and without an end flag.** Mishandling it would leak three extra bytes or leave a frame open that never closes.
- **FIFO running empty mid-event.** This must still yield an end comma rather than a dangling frame.
- **Raw mode.** A wrong slot length would shift every following record off its 24-bit boundary.
- **Back-pressure on the output.** Irregular `sym_ready` stalls catch a design that advances its byte index, or pops the FIFO, on a cycle that was not accepted.

// File: rtl/rf_pkg.sv
package rf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOF,
        ST_REC,
        ST_EOF,
        ST_SKIP
    } rf_state_e;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_SOF,
        ACT_LOAD,
        ACT_EOF,
        ACT_SKIP
    } rf_act_e;

    typedef enum logic [1:0] {
        RK_OTHER,
        RK_HDR,
        RK_SRV
    } rf_kind_e;

    localparam logic [7:0] SYM_SOF_K  = 8'hFC;  // K28.7
    localparam logic [7:0] SYM_EOF_K  = 8'hBC;  // K28.5
    localparam logic [7:0] SYM_IDLE_K = 8'h3C;  // K28.1

    localparam logic [4:0] REC_TAG  = 5'b11101;
    localparam logic [2:0] SUB_HDR  = 3'b001;
    localparam logic [2:0] SUB_SRV  = 3'b111;

endpackage

// File: rtl/rf_rec_classify.sv
module rf_rec_classify
    import rf_pkg::*;
(
    input  logic [7:0] top_byte,
    output rf_kind_e   kind
);
    always_comb begin
        kind = RK_OTHER;
        if (top_byte[7:3] == REC_TAG) begin
            if (top_byte[2:0] == SUB_HDR)
                kind = RK_HDR;
            else if (top_byte[2:0] == SUB_SRV)
                kind = RK_SRV;
        end
    end
endmodule

// File: rtl/rf_byte_split.sv
module rf_byte_split #(
    parameter int REC_W  = 24,
    parameter int BYTE_W = 8,
    localparam int BYTES = REC_W / BYTE_W,
    localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic [REC_W-1:0]  rec,
    input  logic [IDX_W-1:0]  idx,
    output logic [BYTE_W-1:0] byte_o
);
    logic [BYTE_W-1:0] lane [BYTES];

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        // lane 0 is the most significant byte
        assign lane[g] = rec[REC_W-1-g*BYTE_W -: BYTE_W];
    end

    always_comb begin
        byte_o = '0;
        for (int i = 0; i < BYTES; i++) begin
            if (idx == IDX_W'(i))
                byte_o = lane[i];
        end
    end
endmodule

// File: rtl/rf_sym_mux.sv
module rf_sym_mux
    import rf_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  rf_state_e         state,
    input  logic              raw_mode,
    input  logic [BYTE_W-1:0] filler,
    input  logic [BYTE_W-1:0] rec_byte,
    output logic [BYTE_W-1:0] sym_data,
    output logic              sym_k
);
    always_comb begin
        sym_data = '0;
        sym_k    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                sym_data = raw_mode ? filler : BYTE_W'(SYM_IDLE_K);
                sym_k    = !raw_mode;
            end
            ST_SOF: begin
                sym_data = raw_mode ? filler : BYTE_W'(SYM_SOF_K);
                sym_k    = !raw_mode;
            end
            ST_EOF: begin
                sym_data = raw_mode ? filler : BYTE_W'(SYM_EOF_K);
                sym_k    = !raw_mode;
            end
            ST_REC: begin
                sym_data = rec_byte;
                sym_k    = 1'b0;
            end
            ST_SKIP: begin
                sym_data = '0;
                sym_k    = 1'b0;
            end
            default: begin
                sym_data = '0;
                sym_k    = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/record_framer.sv
module record_framer
    import rf_pkg::*;
#(
    parameter int REC_W  = 24,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    input  logic [REC_W-1:0]  rec_data,
    input  logic              rec_last,
    output logic              rec_ready,
    input  logic              raw_mode,
    input  logic [BYTE_W-1:0] filler_byte,
    output logic              sym_valid,
    input  logic              sym_ready,
    output logic [BYTE_W-1:0] sym_data,
    output logic              sym_k
);
    localparam int BYTES = REC_W / BYTE_W;
    localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTES - 1);

    rf_state_e         state_q, nxt_state;
    rf_act_e           act, ofr_act, ifr_act;
    rf_kind_e          head_kind;
    logic [IDX_W-1:0]  cnt_q;
    logic [REC_W-1:0]  held_q;
    logic              held_last_q;
    logic              in_frame_q;
    logic              sr_seen_q;
    logic              prev_sof_q;
    logic              fire, slot_end, advance;
    logic [BYTE_W-1:0] rec_byte;

    rf_rec_classify u_classify (
        .top_byte (rec_data[REC_W-1 -: 8]),
        .kind     (head_kind)
    );

    rf_byte_split #(.REC_W(REC_W), .BYTE_W(BYTE_W)) u_split (
        .rec    (held_q),
        .idx    (cnt_q),
        .byte_o (rec_byte)
    );

    rf_sym_mux #(.BYTE_W(BYTE_W)) u_mux (
        .state    (state_q),
        .raw_mode (raw_mode),
        .filler   (filler_byte),
        .rec_byte (rec_byte),
        .sym_data (sym_data),
        .sym_k    (sym_k)
    );

    assign sym_valid = (state_q != ST_SKIP);
    assign fire      = sym_valid && sym_ready;

    // a record slot spans all bytes; a control slot spans one byte,
    // or a full empty record when raw mode is on
    always_comb begin
        slot_end = 1'b0;
        unique case (state_q)
            ST_REC:                  slot_end = (cnt_q == LAST_IDX);
            ST_IDLE, ST_SOF, ST_EOF: slot_end = raw_mode ? (cnt_q == LAST_IDX) : 1'b1;
            ST_SKIP:                 slot_end = 1'b1;
            default:                 slot_end = 1'b0;
        endcase
    end

    assign advance = (state_q == ST_SKIP) || (fire && slot_end);

    // decisions outside and inside a frame
    always_comb begin
        ofr_act = ACT_IDLE;
        if (rec_valid)
            ofr_act = (head_kind == RK_HDR) ? ACT_SOF : ACT_LOAD;

        ifr_act = ACT_LOAD;
        if (held_last_q || !rec_valid || head_kind == RK_HDR)
            ifr_act = ACT_EOF;
        else if (head_kind == RK_SRV && sr_seen_q)
            ifr_act = ACT_SKIP;
    end

    always_comb begin
        act = ACT_IDLE;
        unique case (state_q)
            ST_IDLE: act = ofr_act;
            ST_EOF:  act = ofr_act;
            ST_SOF:  act = ACT_LOAD;
            ST_REC:  act = in_frame_q ? ifr_act : ofr_act;
            ST_SKIP: act = ifr_act;
            default: act = ACT_IDLE;
        endcase
    end

    assign rec_ready = advance && (act == ACT_LOAD || act == ACT_SKIP);

    always_comb begin
        nxt_state = state_q;
        if (advance) begin
            unique case (act)
                ACT_IDLE: nxt_state = ST_IDLE;
                ACT_SOF:  nxt_state = ST_SOF;
                ACT_LOAD: nxt_state = ST_REC;
                ACT_EOF:  nxt_state = ST_EOF;
                ACT_SKIP: nxt_state = ST_SKIP;
                default:  nxt_state = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= nxt_state;
    end

    // record holding, byte index and frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            held_q      <= '0;
            held_last_q <= 1'b0;
            in_frame_q  <= 1'b0;
            sr_seen_q   <= 1'b0;
            prev_sof_q  <= 1'b0;
        end else begin
            if (fire)
                prev_sof_q <= sym_k && (sym_data == BYTE_W'(SYM_SOF_K));
            if (advance) begin
                cnt_q <= '0;
                unique case (act)
                    ACT_LOAD: begin
                        held_q      <= rec_data;
                        held_last_q <= rec_last;
                        if (state_q == ST_SOF) begin
                            in_frame_q <= 1'b1;
                            sr_seen_q  <= 1'b0;
                        end else if (in_frame_q) begin
                            sr_seen_q <= sr_seen_q || (head_kind == RK_SRV);
                        end
                    end
                    ACT_SKIP: held_last_q <= rec_last;
                    ACT_EOF:  in_frame_q  <= 1'b0;
                    ACT_IDLE, ACT_SOF: ;
                    default: ;
                endcase
            end else if (fire) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // checks next to the logic they guard
    assert_no_double_sof_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && prev_sof_q) |-> !(sym_k && sym_data == BYTE_W'(SYM_SOF_K)));

    assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym_data) && $stable(sym_k)));

    assert_pop_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rec_ready |-> rec_valid);

    assert_raw_no_k_R8: assert property (@(posedge clk) disable iff (!rst_n)
        raw_mode |-> !sym_k);

    assert_rec_bytes_plain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REC) |-> !sym_k);

    assert_sof_pops_header_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SOF && advance) |-> (rec_valid && head_kind == RK_HDR));

endmodule

// File: tb/record_framer_tb.sv
`timescale 1ns/1ps
module record_framer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rec_valid = 1'b0;
    logic [23:0] rec_data = '0;
    logic        rec_last = 1'b0;
    logic        rec_ready;
    logic        raw_mode = 1'b0;
    logic [7:0]  filler_byte = 8'h00;
    logic        sym_valid;
    logic        sym_ready = 1'b1;
    logic [7:0]  sym_data;
    logic        sym_k;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    record_framer dut_i (
        .clk(clk), .rst_n(rst_n),
        .rec_valid(rec_valid), .rec_data(rec_data), .rec_last(rec_last),
        .rec_ready(rec_ready),
        .raw_mode(raw_mode), .filler_byte(filler_byte),
        .sym_valid(sym_valid), .sym_ready(sym_ready),
        .sym_data(sym_data), .sym_k(sym_k)
    );

    // scenario records: bit 24 = last flag
    logic [24:0] recs [$];
    logic [24:0] fq   [$];
    logic [8:0]  exp_q [$];
    string       tag_q [$];

    function automatic logic [23:0] mk_hdr(input logic [3:0] trig, input logic [7:0] bc);
        return {5'b11101, 3'b001, 4'b0000, trig, bc};
    endfunction
    function automatic logic [23:0] mk_dr(input logic [6:0] col, input logic [8:0] row,
                                          input logic [3:0] ta, input logic [3:0] tb);
        return {col, row, ta, tb};
    endfunction
    function automatic logic [23:0] mk_ar(input logic t, input logic [14:0] a);
        return {5'b11101, 3'b010, t, a};
    endfunction
    function automatic logic [23:0] mk_vr(input logic [15:0] v);
        return {5'b11101, 3'b100, v};
    endfunction
    function automatic logic [23:0] mk_sr(input logic [15:0] m);
        return {5'b11101, 3'b111, m};
    endfunction

    function automatic bit is_hdr(input logic [24:0] r);
        return r[23:16] == 8'hE9;
    endfunction
    function automatic bit is_srv(input logic [24:0] r);
        return r[23:16] == 8'hEF;
    endfunction

    task automatic push_ctl(input logic [7:0] code, input bit raw, input logic [7:0] fill,
                            input string tag);
        if (raw) begin
            for (int j = 0; j < 3; j++) begin
                exp_q.push_back({1'b0, fill});
                tag_q.push_back("R8");
            end
        end else begin
            exp_q.push_back({1'b1, code});
            tag_q.push_back(tag);
        end
    endtask

    task automatic push_rec(input logic [24:0] r);
        exp_q.push_back({1'b0, r[23:16]}); tag_q.push_back("R3");
        exp_q.push_back({1'b0, r[15:8]});  tag_q.push_back("R3");
        exp_q.push_back({1'b0, r[7:0]});   tag_q.push_back("R3");
    endtask

    // reference model: expected accepted byte stream for a FIFO preloaded with recs
    task automatic build_expected(input bit raw, input logic [7:0] fill);
        int  i = 0;
        int  n = recs.size();
        bit  last, sr_seen;
        exp_q.delete(); tag_q.delete();
        push_ctl(8'h3C, raw, fill, "R1");
        while (i < n) begin
            if (is_hdr(recs[i])) begin
                push_ctl(8'hFC, raw, fill, "R2");
                push_rec(recs[i]);
                last = recs[i][24]; sr_seen = 1'b0; i++;
                forever begin
                    if (last || i == n || is_hdr(recs[i])) begin
                        push_ctl(8'hBC, raw, fill, "R4");
                        break;
                    end
                    if (is_srv(recs[i]) && sr_seen) begin   // R7 surplus dropped
                        last = recs[i][24]; i++;
                        continue;
                    end
                    if (is_srv(recs[i])) sr_seen = 1'b1;
                    push_rec(recs[i]);
                    last = recs[i][24]; i++;
                end
            end else begin
                push_rec(recs[i]);   // R6 unframed
                i++;
            end
        end
        push_ctl(8'h3C, raw, fill, "R1");
        push_ctl(8'h3C, raw, fill, "R1");
    endtask

    task automatic run_scn(input string name, input bit raw, input logic [7:0] fill,
                           input int stall_mod);
        bit         prev_stall = 1'b0;
        logic [8:0] prev_sym = '0;
        int         cyc = 0;
        @(negedge clk);
        rst_n = 1'b0;
        raw_mode = raw;
        filler_byte = fill;
        sym_ready = 1'b1;
        fq = recs;
        build_expected(raw, fill);
        rec_valid = fq.size() > 0;
        rec_data  = rec_valid ? fq[0][23:0] : '0;
        rec_last  = rec_valid ? fq[0][24] : 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        while (exp_q.size() > 0 && cyc < 3000 && !done) begin
            rec_valid = fq.size() > 0;
            rec_data  = rec_valid ? fq[0][23:0] : '0;
            rec_last  = rec_valid ? fq[0][24] : 1'b0;
            sym_ready = (stall_mod == 0) ? 1'b1 : ((cyc % stall_mod) != 1);
            #1;
            if (cyc == 0) begin
                checks++;
                if (sym_valid !== 1'b1) begin
                    fails++;
                    $display("FAIL R1 %s: sym_valid after reset act=%b exp=1", name, sym_valid);
                end
                if (fq.size() == 0) begin
                    checks++;
                    if (rec_ready !== 1'b0) begin
                        fails++;
                        $display("FAIL R1 %s: rec_ready with empty FIFO act=%b exp=0", name, rec_ready);
                    end
                end
            end
            if (prev_stall) begin
                checks++;
                if (sym_valid !== 1'b1 || {sym_k, sym_data} !== prev_sym) begin
                    fails++;
                    $display("FAIL R9 %s: stalled output changed act=%h exp=%h", name,
                             {sym_k, sym_data}, prev_sym);
                end
            end
            prev_stall = sym_valid && !sym_ready;
            prev_sym   = {sym_k, sym_data};
            if (sym_valid && sym_ready) begin
                logic [8:0] e = exp_q.pop_front();
                string      t = tag_q.pop_front();
                checks++;
                if ({sym_k, sym_data} !== e) begin
                    fails++;
                    $display("FAIL %s %s: symbol act=k%b/%h exp=k%b/%h", t, name,
                             sym_k, sym_data, e[8], e[7:0]);
                end
            end
            if (rec_ready) begin
                checks++;
                if (fq.size() == 0) begin
                    fails++;
                    $display("FAIL R9 %s: pop with empty FIFO act=1 exp=0", name);
                end else begin
                    void'(fq.pop_front());
                end
            end
            @(negedge clk);
            cyc++;
        end
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R4 %s: stream incomplete act=%0d left exp=0", name, exp_q.size());
        end
    endtask

    initial begin
        // S0: empty FIFO, idle only (R1)
        recs.delete();
        run_scn("empty", 1'b0, 8'h00, 0);

        // S1: full event closed by last on service record, then unframed pair (R2 R3 R4 R6 R10)
        recs.delete();
        recs.push_back({1'b0, mk_hdr(4'h5, 8'h3A)});
        recs.push_back({1'b0, mk_dr(7'd80, 9'd335, 4'h9, 4'h2)});
        recs.push_back({1'b0, mk_dr(7'd1, 9'd0, 4'hF, 4'h0)});
        recs.push_back({1'b1, mk_sr(16'hBEEF)});
        recs.push_back({1'b0, mk_ar(1'b1, 15'h1234)});
        recs.push_back({1'b0, mk_vr(16'hCAFE)});
        run_scn("event_and_pair", 1'b0, 8'h00, 0);

        // S2: header inside open frame forces EOF then SOF (R4 R5), with stalls (R9)
        recs.delete();
        recs.push_back({1'b0, mk_hdr(4'h1, 8'h10)});
        recs.push_back({1'b0, mk_dr(7'd29, 9'd100, 4'h3, 4'h4)});
        recs.push_back({1'b0, mk_hdr(4'h2, 8'h11)});
        recs.push_back({1'b1, mk_dr(7'd30, 9'd101, 4'h5, 4'h6)});
        recs.push_back({1'b1, mk_hdr(4'h3, 8'h12)});
        run_scn("back_to_back", 1'b0, 8'h00, 3);

        // S3: surplus service records (R7)
        recs.delete();
        recs.push_back({1'b0, mk_hdr(4'h7, 8'h77)});
        recs.push_back({1'b0, mk_sr(16'h0001)});
        recs.push_back({1'b1, mk_sr(16'h0002)});
        recs.push_back({1'b0, mk_hdr(4'h8, 8'h78)});
        recs.push_back({1'b0, mk_sr(16'h0003)});
        recs.push_back({1'b0, mk_sr(16'h0004)});
        recs.push_back({1'b1, mk_dr(7'd58, 9'd7, 4'hA, 4'hB)});
        run_scn("extra_service", 1'b0, 8'h00, 4);

        // S4: frame closes when FIFO runs dry (R4)
        recs.delete();
        recs.push_back({1'b0, mk_hdr(4'h9, 8'hF0)});
        recs.push_back({1'b0, mk_dr(7'd79, 9'd256, 4'h1, 4'h1)});
        run_scn("runs_empty", 1'b0, 8'h00, 0);

        // S5: raw mode with filler 0xCC (R8) and stalls
        recs.delete();
        recs.push_back({1'b0, mk_hdr(4'hC, 8'h01)});
        recs.push_back({1'b1, mk_dr(7'd40, 9'd200, 4'h7, 4'h8)});
        recs.push_back({1'b0, mk_vr(16'h5A5A)});
        run_scn("raw_filler", 1'b1, 8'hCC, 5);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: run hung act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule